// File: doc/BRIEF.md
# GPIO Pad Controller with Per-Pad Function Select

This block controls 56 chip pads through a small register bus with 32-bit data. Pads are grouped into banks of sixteen: banks 0, 1 and 2 are complete, and bank 3 holds only pads 48 to 55. For every pad the block stores the output level, the drive direction, a two-bit function code, a drive-type bit and two pull controls. It also samples the pad level through a synchroniser so software can read it.

The function code decides what drives the pad. Code 0 means the GPIO registers own it. Codes 1 to 3 hand output data and output enable to one of three generic peripheral slots, and the synchronised pad level goes back to that slot. The drive-type bit and the pull controls apply in every mode.

The half bank has no complete register window of its own. Its drive-type, pull and high function-bit registers are placed at spare offsets inside the windows of banks 0 and 1.

Top module: `gpio_pad_mux`

## Requirements
- R1: After synchronous reset every stored bit is 0. Every pad is then an input (`pad_oe`=0) with `pad_out`=0 and no pull, and every `alt_di` bit is 0.
- R2: Bank b (0..2) has a window at byte address b*0x30. The offsets in each window are: 0x00 output level, 0x04 sampled input (read-only), 0x08 direction, 0x0C function bit 0, 0x10 function bit 1, 0x14 drive type, 0x1C pull select and 0x20 pull enable. Bit i of each register belongs to pad b*16+i, and `bus_rdata[31:16]` reads 0.
- R3: For bank 3, the drive-type, pull-select and pull-enable registers are at 0x24, 0x28 and 0x2C, and function bit 1 is at 0x54. Its output, input, direction and function bit 0 registers are at 0x90, 0x94, 0x98 and 0x9C.
- R4: Bank 3 registers keep only bits 7:0, and their upper bits read 0. Any address that is not listed in R2 or R3 reads 0, and a write to it changes no register. Writes to an input register have no effect.
- R5: A pad level appears in the input register at the second rising clock edge after it is applied.
- R6: With function code 0 and drive type 1 (push-pull), `pad_oe` equals the direction bit and `pad_out` equals the output bit.
- R7: With drive type 0 (open-drain), `pad_oe` is set only when the drive is enabled and the data is 0, and `pad_out` is 0.
- R8: With pull enable 0, `pad_pu` and `pad_pd` are both 0. With pull enable 1, a pull select of 0 gives `pad_pu`=1 and a pull select of 1 gives `pad_pd`=1.
- R9: The function code is {function bit 1, function bit 0}. A code c from 1 to 3 takes data and enable from `alt_do`/`alt_oe` bit (c-1)*56+pad and ignores the GPIO output and direction bits.
- R10: `alt_di` bit (c-1)*56+pad carries the synchronised pad level when the pad's code is c, and 0 otherwise.
- R11: The drive type and pull settings still apply while a peripheral slot owns the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 56 | Raw pad levels |
| pad_oe | output | 56 | Pad output enable |
| pad_out | output | 56 | Pad output level |
| pad_pu | output | 56 | Pull-up request |
| pad_pd | output | 56 | Pull-down request |
| alt_do | input | 168 | Peripheral output data, slot-major |
| alt_oe | input | 168 | Peripheral output enable, slot-major |
| alt_di | output | 168 | Synchronised pad level to the owning slot |

## Verification
Most stored state drives the pad outputs combinationally. A wrong bit therefore shows on `pad_oe`, `pad_out`, `pad_pu` or `pad_pd` one cycle after the write that should have set it, and it also shows on `bus_rdata` for the matching address. A decode error for the relocated half-bank registers can be hidden when the register is only read back. For that reason the bench also checks the pad-side effect of each relocated register, along with bank 3 bits above 7 and the gap offsets. A synchroniser that has the wrong number of stages shows up as an input register that is correct one edge too early or one edge too late.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int AW      = 8;
    localparam int DW      = 32;
    localparam int BANK_W  = 16;
    localparam int NPAD    = 56;
    localparam int NSLOT   = 3;
    localparam int NBANK   = (NPAD + BANK_W - 1) / BANK_W;
    localparam int BIW     = $clog2(NBANK);
    localparam int NSTORE  = 7;

    localparam logic [AW-1:0]  WIN      = 8'h30;
    localparam logic [AW-1:0]  NBANK_A  = AW'(NBANK);
    localparam logic [AW-1:0]  HALF_A   = AW'(NBANK - 1);
    localparam logic [BIW-1:0] HALF_ID  = BIW'(NBANK - 1);
    // relocated half-bank registers
    localparam logic [AW-1:0]  REL_OD   = 8'h24;
    localparam logic [AW-1:0]  REL_PSEL = 8'h28;
    localparam logic [AW-1:0]  REL_PEN  = 8'h2C;
    localparam logic [AW-1:0]  REL_FS1  = 8'h54;

    typedef enum logic [2:0] {
        FLD_OUT  = 3'd0,
        FLD_DIR  = 3'd1,
        FLD_FS0  = 3'd2,
        FLD_FS1  = 3'd3,
        FLD_OD   = 3'd4,
        FLD_PSEL = 3'd5,
        FLD_PEN  = 3'd6,
        FLD_IN   = 3'd7
    } fld_e;

    typedef struct packed {
        logic           hit;
        fld_e           fld;
        logic [BIW-1:0] bank;
    } dec_t;

    typedef struct packed {
        logic [1:0] fcode;
        logic       dout;
        logic       dir;
        logic       push;   // 1 = push-pull, 0 = open-drain
        logic       pen;
        logic       psel;   // 0 = up, 1 = down
    } pad_cfg_t;

    function automatic dec_t decode(input logic [AW-1:0] a);
        dec_t d;
        logic [AW-1:0] bsel;
        logic [AW-1:0] off;
        d    = '{hit: 1'b0, fld: FLD_OUT, bank: '0};
        bsel = a / WIN;
        off  = a - bsel * WIN;
        if (a == REL_OD)        d = '{hit: 1'b1, fld: FLD_OD,   bank: HALF_ID};
        else if (a == REL_PSEL) d = '{hit: 1'b1, fld: FLD_PSEL, bank: HALF_ID};
        else if (a == REL_PEN)  d = '{hit: 1'b1, fld: FLD_PEN,  bank: HALF_ID};
        else if (a == REL_FS1)  d = '{hit: 1'b1, fld: FLD_FS1,  bank: HALF_ID};
        else if (bsel < NBANK_A) begin
            d.bank = bsel[BIW-1:0];
            d.hit  = 1'b1;
            case (off)
                8'h00:   d.fld = FLD_OUT;
                8'h04:   d.fld = FLD_IN;
                8'h08:   d.fld = FLD_DIR;
                8'h0C:   d.fld = FLD_FS0;
                8'h10:   d.fld = FLD_FS1;
                8'h14:   d.fld = FLD_OD;
                8'h1C:   d.fld = FLD_PSEL;
                8'h20:   d.fld = FLD_PEN;
                default: d.hit = 1'b0;
            endcase
            if (bsel == HALF_A && off > 8'h0C) d.hit = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_mux_pkg::*;
#(
    parameter int W = NPAD
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg1, stg2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1 <= '0;
            stg2 <= '0;
        end else begin
            stg1 <= d;
            stg2 <= stg1;
        end
    end

    assign q = stg2;

    // edges since reset, saturating, for the latency check
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_sync_two_stage_r5: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mux_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr,
    input  logic [AW-1:0]                addr,
    input  logic [BANK_W-1:0]            wdata,
    output logic [DW-1:0]                rdata,
    input  logic [NPAD-1:0]              sync_in,
    output logic [NSTORE-1:0][NPAD-1:0]  fld
);
    dec_t dec;
    assign dec = decode(addr);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        localparam int BW = (NPAD - LO < BANK_W) ? (NPAD - LO) : BANK_W;
        localparam logic [BIW-1:0] BID = BIW'(b);
        for (genvar f = 0; f < NSTORE; f++) begin : g_fld
            localparam fld_e FID = fld_e'(f);
            logic [BW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr && dec.hit && dec.bank == BID && dec.fld == FID)
                    q <= wdata[BW-1:0];
            end
            assign fld[f][LO +: BW] = q;
        end
    end

    logic [NBANK*BANK_W-1:0] ext;
    always_comb begin
        ext = '0;
        case (dec.fld)
            FLD_OUT:  ext[NPAD-1:0] = fld[FLD_OUT];
            FLD_DIR:  ext[NPAD-1:0] = fld[FLD_DIR];
            FLD_FS0:  ext[NPAD-1:0] = fld[FLD_FS0];
            FLD_FS1:  ext[NPAD-1:0] = fld[FLD_FS1];
            FLD_OD:   ext[NPAD-1:0] = fld[FLD_OD];
            FLD_PSEL: ext[NPAD-1:0] = fld[FLD_PSEL];
            FLD_PEN:  ext[NPAD-1:0] = fld[FLD_PEN];
            default:  ext[NPAD-1:0] = sync_in;
        endcase
        rdata = '0;
        if (dec.hit) rdata = DW'(ext[dec.bank*BANK_W +: BANK_W]);
    end

    p_wr_takes_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && dec.hit && dec.fld == FLD_OUT && dec.bank == '0)
        |=> (fld[FLD_OUT][BANK_W-1:0] == $past(wdata)));

    p_miss_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && !dec.hit) |=> $stable(fld));

endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
    import gpio_mux_pkg::*;
(
    input  pad_cfg_t         cfg,
    input  logic [NSLOT-1:0] alt_do,
    input  logic [NSLOT-1:0] alt_oe,
    input  logic             sync_in,
    output logic             pad_oe,
    output logic             pad_out,
    output logic             pull_up,
    output logic             pull_dn,
    output logic [NSLOT-1:0] alt_di
);
    logic d, e;

    always_comb begin
        case (cfg.fcode)
            2'd0:    begin d = cfg.dout;  e = cfg.dir;   end
            2'd1:    begin d = alt_do[0]; e = alt_oe[0]; end
            2'd2:    begin d = alt_do[1]; e = alt_oe[1]; end
            default: begin d = alt_do[2]; e = alt_oe[2]; end
        endcase
        pad_oe  = cfg.push ? e : (e & ~d);
        pad_out = cfg.push & d;
        pull_up = cfg.pen & ~cfg.psel;
        pull_dn = cfg.pen & cfg.psel;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_di
        localparam logic [1:0] CODE = 2'(s + 1);
        assign alt_di[s] = sync_in & (cfg.fcode == CODE);
    end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_mux_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [55:0]           pad_in,
    output logic [55:0]           pad_oe,
    output logic [55:0]           pad_out,
    output logic [55:0]           pad_pu,
    output logic [55:0]           pad_pd,
    input  logic [167:0]          alt_do,
    input  logic [167:0]          alt_oe,
    output logic [167:0]          alt_di
);
    logic [NPAD-1:0]             sync_in;
    logic [NSTORE-1:0][NPAD-1:0] fld;

    gpio_in_sync #(.W(NPAD)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    gpio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata[BANK_W-1:0]),
        .rdata   (bus_rdata),
        .sync_in (sync_in),
        .fld     (fld)
    );

    for (genvar p = 0; p < NPAD; p++) begin : g_pad
        pad_cfg_t         cfg;
        logic [NSLOT-1:0] s_do, s_oe, s_di;

        assign cfg = '{fcode: {fld[FLD_FS1][p], fld[FLD_FS0][p]},
                       dout:  fld[FLD_OUT][p],
                       dir:   fld[FLD_DIR][p],
                       push:  fld[FLD_OD][p],
                       pen:   fld[FLD_PEN][p],
                       psel:  fld[FLD_PSEL][p]};

        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            assign s_do[s]            = alt_do[s*NPAD + p];
            assign s_oe[s]            = alt_oe[s*NPAD + p];
            assign alt_di[s*NPAD + p] = s_di[s];
        end

        gpio_pad_cell u_cell (
            .cfg     (cfg),
            .alt_do  (s_do),
            .alt_oe  (s_oe),
            .sync_in (sync_in[p]),
            .pad_oe  (pad_oe[p]),
            .pad_out (pad_out[p]),
            .pull_up (pad_pu[p]),
            .pull_dn (pad_pd[p]),
            .alt_di  (s_di)
        );

        p_gpio_oe_r6: assert property (@(posedge clk) disable iff (rst)
            (cfg.fcode == 2'd0 && cfg.push) |-> (pad_oe[p] == cfg.dir));

        p_od_no_high_r7: assert property (@(posedge clk) disable iff (rst)
            (!cfg.push) |-> !pad_out[p]);

        p_slot_onehot_r10: assert property (@(posedge clk) disable iff (rst)
            $onehot0(s_di));
    end

    p_pull_excl_r8: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_pd) == '0);

endmodule

// File: tb/gpio_pad_mux_tb.sv
module gpio_pad_mux_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_wr;
    logic [7:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [55:0]  pad_in;
    logic [55:0]  pad_oe, pad_out, pad_pu, pad_pd;
    logic [167:0] alt_do, alt_oe, alt_di;

    int total = 0;
    int bad   = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    gpio_pad_mux u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .alt_do(alt_do), .alt_oe(alt_oe), .alt_di(alt_di)
    );

    typedef struct packed {
        logic [7:0]  wa;
        logic [31:0] wd;
        logic [7:0]  ra;
        logic [31:0] re;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 32'hFFFF_A5C3, 8'h00, 32'h0000_A5C3}, // R2 bank0 out
        '{8'h38, 32'h0000_1234, 8'h38, 32'h0000_1234}, // R2 bank1 dir
        '{8'h6C, 32'h0000_BEEF, 8'h6C, 32'h0000_BEEF}, // R2 bank2 fs0
        '{8'h80, 32'h0000_0F0F, 8'h80, 32'h0000_0F0F}, // R2 bank2 pen
        '{8'h4C, 32'hFFFF_0005, 8'h4C, 32'h0000_0005}, // R2 bank1 psel
        '{8'h24, 32'h0000_FFFF, 8'h24, 32'h0000_00FF}, // R3 R4 half od
        '{8'h24, 32'h0000_FFFF, 8'h14, 32'h0000_0000}, // R3 bank0 od untouched
        '{8'h54, 32'h0000_1234, 8'h54, 32'h0000_0034}, // R3 half fs1
        '{8'h90, 32'h0000_ABCD, 8'h90, 32'h0000_00CD}, // R3 half out
        '{8'hA0, 32'h0000_FFFF, 8'h54, 32'h0000_0034}, // R4 no fs1 at normal spot
        '{8'hB0, 32'h0000_FFFF, 8'hB0, 32'h0000_0000}, // R4 unmapped
        '{8'h18, 32'h0000_FFFF, 8'h18, 32'h0000_0000}, // R4 gap offset
        '{8'h04, 32'h0000_FFFF, 8'h04, 32'h0000_0000}  // R4 input is read-only
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; alt_do = '0; alt_oe = '0;
        do_reset();

        // R1 reset state
        #2;
        chk("R1 pad_oe", 64'(pad_oe), 64'h0);
        chk("R1 pad_out", 64'(pad_out), 64'h0);
        chk("R1 pulls", 64'(pad_pu | pad_pd), 64'h0);
        chk("R1 alt_di", 64'(|alt_di), 64'h0);
        rd(8'h38, rv); chk("R1 dir reads 0", 64'(rv), 64'h0);

        // table: R2 R3 R4 register map
        for (int i = 0; i < NV; i++) begin
            wr(TBL[i].wa, TBL[i].wd);
            rd(TBL[i].ra, rv);
            chk($sformatf("R2/R3/R4 map row %0d", i), 64'(rv), 64'(TBL[i].re));
        end

        do_reset();

        // R5 two-edge input latency
        @(negedge clk); pad_in = 56'h5A_1234_5678_9ABC;
        @(posedge clk); #1;
        rd(8'h04, rv); chk("R5 not yet after one edge", 64'(rv), 64'h0);
        rd(8'h04, rv); chk("R5 bank0 in", 64'(rv), 64'h9ABC);
        rd(8'h34, rv); chk("R5 bank1 in", 64'(rv), 64'h5678);
        rd(8'h64, rv); chk("R5 bank2 in", 64'(rv), 64'h1234);
        rd(8'h94, rv); chk("R5 half in", 64'(rv), 64'h005A);
        pad_in = '0;

        // R6 push-pull gpio
        wr(8'h14, 32'hFFFF); wr(8'h08, 32'h00FF); wr(8'h00, 32'h0F0F);
        #2;
        chk("R6 oe", 64'(pad_oe[15:0]), 64'h00FF);
        chk("R6 out", 64'(pad_out[15:0]), 64'h0F0F);

        // R7 open-drain
        wr(8'h14, 32'h0000);
        #2;
        chk("R7 oe", 64'(pad_oe[15:0]), 64'h00F0);
        chk("R7 out", 64'(pad_out[15:0]), 64'h0);

        // R8 pulls, full bank and relocated half bank
        chk("R8 no pull before enable", 64'(pad_pu | pad_pd), 64'h0);
        wr(8'h50, 32'h000F); wr(8'h4C, 32'h0005);
        wr(8'h2C, 32'h0003); wr(8'h28, 32'h0002);
        #2;
        chk("R8 pu bank1", 64'(pad_pu[31:16]), 64'h000A);
        chk("R8 pd bank1", 64'(pad_pd[31:16]), 64'h0005);
        chk("R8 pu half", 64'(pad_pu[55:48]), 64'h01);
        chk("R8 pd half", 64'(pad_pd[55:48]), 64'h02);

        // R9 R11 peripheral slots on pads 48 (code 3) and 49 (code 1)
        wr(8'h9C, 32'h03); wr(8'h54, 32'h01); wr(8'h24, 32'h01);
        @(negedge clk);
        alt_do[2*56+48] = 1'b1; alt_oe[2*56+48] = 1'b1;
        alt_do[0*56+49] = 1'b0; alt_oe[0*56+49] = 1'b1;
        #2;
        chk("R9 oe from slot", 64'(pad_oe[49:48]), 64'h3);
        chk("R9 out from slot", 64'(pad_out[49:48]), 64'h1);
        alt_do[0*56+49] = 1'b1;
        #2;
        chk("R11 open-drain in slot mode", 64'({pad_oe[49], pad_out[49]}), 64'h0);
        chk("R11 pull kept in slot mode", 64'(pad_pu[48]), 64'h1);
        wr(8'h24, 32'h00);
        #2;
        chk("R11 od releases high slot data", 64'(pad_oe[48]), 64'h0);

        // R10 input routing
        @(negedge clk);
        pad_in = '0; pad_in[48] = 1'b1; pad_in[49] = 1'b1; pad_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        chk("R10 slot3 pad48", 64'(alt_di[2*56+48]), 64'h1);
        chk("R10 other slots pad48", 64'({alt_di[56+48], alt_di[48]}), 64'h0);
        chk("R10 slot1 pad49", 64'(alt_di[49]), 64'h1);
        chk("R10 gpio pad0 gets none", 64'({alt_di[112], alt_di[56], alt_di[0]}), 64'h0);
        rd(8'h04, rv); chk("R10 gpio read", 64'(rv[0]), 64'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule